// File: doc/BRIEF.md
# Two-Reference Capacitor Weight Tracker

This block schedules and stores the digital weights used to calibrate a charge-redistribution converter whose array is built from two sizes of unit capacitor: 16 small units and 32 large units, each large unit being eight times a small one. Each sample is converted twice, with one unit swapped against a reference between the two conversions. For every sample the block offers a plan: the mode flag, which unit to swap, and which group terminates the array. It then accepts one signed weight correction for that unit and adds it to the stored weight. A separate code-summing unit reads every weight at once from a flat read port.

Small units 1 to 15 are estimated against small unit 0, which never changes. Large units 1 to 31 are estimated against a composite reference built from small units 8 to 15. That composite is itself still being estimated. So after each full pass over the small units, the block shifts every large-unit weight by the change in the composite's summed weight. Large unit 0 serves as the termination group during small-unit passes and keeps its initial weight.

The plan leaves on a valid/ready pair and the correction arrives on another valid/ready pair. A plan stays offered, with its fields frozen, until `plan_ready` is high. Only one correction is outstanding at a time: `upd_ready` is high only between acceptance of a plan and acceptance of its correction. A correction offered while `upd_ready` is low is not taken. The consumer may stall either channel for any number of cycles.

Top module: `cal_two_ref_tracker`

## Requirements
- R1: After reset, every small-unit weight reads 512 (2 scaled by 2^8), every large-unit weight reads 4096 (16 scaled by 2^8), and the first plan offered has flag 1, unit 1 and term select 1.
- R2: In a small pass the plans carry flag 1 (`plan_flag`=2'd1) for units 1 to 15 in increasing order, each with `plan_term`=1, meaning that the first large group terminates the array.
- R3: In a large pass the plans carry flag 2 (`plan_flag`=2'd2) for units 1 to 31 in increasing order, each with `plan_term`=0, meaning that the smallest small group terminates the array.
- R4: After the correction for large unit 31 is accepted, the next cycle offers flag 1, unit 1, and the small-then-large cycle repeats.
- R5: An accepted correction adds `upd_delta` to the weight of the unit named in the most recently accepted plan. The new value shows on the read port in the cycle after the handshake, and no other weight changes from it.
- R6: Small unit 0 and large unit 0 keep their reset weights at all times.
- R7: In the cycle after the correction for small unit 15 is accepted, no plan is offered. In the cycle after that, each of large units 1 to 31 has grown by S - P, where S is the current sum of small weights 8 to 15 and P is that sum at the previous such event (4096 after reset).
- R8: An offered plan keeps `plan_valid` high and its fields unchanged until `plan_ready`. `upd_ready` and `plan_valid` are never high together.
- R9: A correction presented while `upd_ready` is low changes no weight.
- R10: All weight arithmetic is two's complement modulo 2^20, so a weight driven below zero wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| plan_valid | output | 1 | A plan for the next sample is offered |
| plan_ready | input | 1 | Consumer takes the offered plan |
| plan_flag | output | 2 | 1 = small-unit mode, 2 = large-unit mode |
| plan_unit | output | 5 | Index of the unit to swap in the second conversion |
| plan_term | output | 1 | 1 = first large group terminates, 0 = smallest small group terminates |
| upd_valid | input | 1 | A correction is offered |
| upd_ready | output | 1 | Block waits for the correction of the accepted plan |
| upd_delta | input | 20 | Signed correction added to the swapped unit's weight |
| wt_small | output | 320 | Flat read of the 16 small weights, unit i at bits [20i+19:20i] |
| wt_large | output | 640 | Flat read of the 32 large weights, unit i at bits [20i+19:20i] |

## Verification
Each result falls due a fixed number of clock edges after its handshake. A correction appears on the read port one edge after it is accepted. The next plan is offered one edge after a correction, except after small unit 15, where there is a gap of one silent cycle. The shifted large weights appear two edges after that correction. The bench drives inputs on the falling edge and samples on the next falling edge. It checks the no-plan cycle and the shifted bank on those exact edges and compares the whole bank against its own model after every correction. Stalls of several cycles on `plan_ready` confirm that the plan holds. A correction waved while `upd_ready` is low confirms that it is ignored.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam logic [1:0] FLAG_SMALL = 2'd1;
  localparam logic [1:0] FLAG_LARGE = 2'd2;

  typedef enum logic [1:0] {
    ST_OFFER = 2'd0,
    ST_AWAIT = 2'd1,
    ST_SHIFT = 2'd2
  } sched_st_e;
endpackage

// File: rtl/cal_sched.sv
module cal_sched
  import cal_pkg::*;
#(
  parameter int N_SMALL = 16,
  parameter int N_LARGE = 32,
  parameter int UW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          plan_valid,
  input  logic          plan_ready,
  output logic [1:0]    plan_flag,
  output logic [UW-1:0] plan_unit,
  output logic          plan_term,
  input  logic          upd_valid,
  output logic          upd_ready,
  output logic          wr_small,
  output logic          wr_large,
  output logic [UW-1:0] wr_idx,
  output logic          shift_en
);
  localparam logic [UW-1:0] LAST_S = UW'(N_SMALL - 1);
  localparam logic [UW-1:0] LAST_L = UW'(N_LARGE - 1);
  localparam logic [UW-1:0] FIRST  = UW'(1);

  sched_st_e     st;
  logic          large_pass;
  logic [UW-1:0] idx;
  logic          upd_fire;

  assign plan_valid = (st == ST_OFFER);
  assign upd_ready  = (st == ST_AWAIT);
  assign shift_en   = (st == ST_SHIFT);
  assign plan_flag  = large_pass ? FLAG_LARGE : FLAG_SMALL;
  assign plan_unit  = idx;
  assign plan_term  = !large_pass;
  assign upd_fire   = upd_ready && upd_valid;
  assign wr_small   = upd_fire && !large_pass;
  assign wr_large   = upd_fire && large_pass;
  assign wr_idx     = idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_OFFER;
      large_pass <= 1'b0;
      idx        <= FIRST;
    end else begin
      case (st)
        ST_OFFER: if (plan_ready) st <= ST_AWAIT;
        ST_AWAIT: begin
          if (upd_valid) begin
            if (!large_pass && idx == LAST_S) begin
              st         <= ST_SHIFT;
              large_pass <= 1'b1;
              idx        <= FIRST;
            end else if (large_pass && idx == LAST_L) begin
              st         <= ST_OFFER;
              large_pass <= 1'b0;
              idx        <= FIRST;
            end else begin
              st  <= ST_OFFER;
              idx <= idx + UW'(1);
            end
          end
        end
        ST_SHIFT: st <= ST_OFFER;
        default:  st <= ST_OFFER;
      endcase
    end
  end
endmodule

// File: rtl/cal_wbank.sv
module cal_wbank #(
  parameter int             N         = 16,
  parameter int             WW        = 20,
  parameter int             IW        = 5,
  parameter logic [WW-1:0]  INIT      = '0,
  parameter bit             SHIFTABLE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [WW-1:0]   wr_delta,
  input  logic            sh_en,
  input  logic [WW-1:0]   sh_delta,
  output logic [N*WW-1:0] rd_flat
);
  for (genvar g = 0; g < N; g++) begin : g_ent
    if (g == 0) begin : g_ref
      assign rd_flat[g*WW +: WW] = INIT;
    end else begin : g_est
      logic [WW-1:0] w;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          w <= INIT;
        end else if (wr_en && wr_idx == IW'(g)) begin
          w <= w + wr_delta;
        end else if (SHIFTABLE && sh_en) begin
          w <= w + sh_delta;
        end
      end
      assign rd_flat[g*WW +: WW] = w;
    end
  end
endmodule

// File: rtl/cal_cref.sv
module cal_cref #(
  parameter int            N_SMALL   = 16,
  parameter int            WW        = 20,
  parameter int            REF_LO    = 8,
  parameter int            REF_HI    = 15,
  parameter logic [WW-1:0] PREV_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_SMALL*WW-1:0] small_flat,
  input  logic                  shift_en,
  output logic [WW-1:0]         shift_delta
);
  logic [WW-1:0] sum_now;
  logic [WW-1:0] sum_prev;

  always_comb begin
    sum_now = '0;
    for (int i = REF_LO; i <= REF_HI; i++) begin
      sum_now = sum_now + small_flat[i*WW +: WW];
    end
  end

  assign shift_delta = sum_now - sum_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sum_prev <= PREV_INIT;
    else if (shift_en) sum_prev <= sum_now;
  end
endmodule

// File: rtl/cal_two_ref_tracker.sv
module cal_two_ref_tracker #(
  parameter int N_SMALL = 16,
  parameter int N_LARGE = 32,
  parameter int WW      = 20,
  parameter int FRAC    = 8,
  parameter int RATIO   = 8,
  parameter int REF_LO  = 8,
  parameter int REF_HI  = 15,
  parameter int UW      = $clog2(N_LARGE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  plan_valid,
  input  logic                  plan_ready,
  output logic [1:0]            plan_flag,
  output logic [UW-1:0]         plan_unit,
  output logic                  plan_term,
  input  logic                  upd_valid,
  output logic                  upd_ready,
  input  logic [WW-1:0]         upd_delta,
  output logic [N_SMALL*WW-1:0] wt_small,
  output logic [N_LARGE*WW-1:0] wt_large
);
  localparam logic [WW-1:0] SMALL_INIT = WW'(2) << FRAC;
  localparam logic [WW-1:0] LARGE_INIT = WW'(2 * RATIO) << FRAC;
  localparam logic [WW-1:0] PREV_INIT  = WW'((REF_HI - REF_LO + 1) * 2) << FRAC;

  logic          wr_small, wr_large, shift_en;
  logic [UW-1:0] wr_idx;
  logic [WW-1:0] shift_delta;

  cal_sched #(.N_SMALL(N_SMALL), .N_LARGE(N_LARGE), .UW(UW)) u_sched (
    .clk(clk), .rst_n(rst_n),
    .plan_valid(plan_valid), .plan_ready(plan_ready),
    .plan_flag(plan_flag), .plan_unit(plan_unit), .plan_term(plan_term),
    .upd_valid(upd_valid), .upd_ready(upd_ready),
    .wr_small(wr_small), .wr_large(wr_large), .wr_idx(wr_idx),
    .shift_en(shift_en)
  );

  cal_wbank #(.N(N_SMALL), .WW(WW), .IW(UW), .INIT(SMALL_INIT), .SHIFTABLE(1'b0)) u_small (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_small), .wr_idx(wr_idx), .wr_delta(upd_delta),
    .sh_en(1'b0), .sh_delta('0),
    .rd_flat(wt_small)
  );

  cal_wbank #(.N(N_LARGE), .WW(WW), .IW(UW), .INIT(LARGE_INIT), .SHIFTABLE(1'b1)) u_large (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_large), .wr_idx(wr_idx), .wr_delta(upd_delta),
    .sh_en(shift_en), .sh_delta(shift_delta),
    .rd_flat(wt_large)
  );

  cal_cref #(.N_SMALL(N_SMALL), .WW(WW), .REF_LO(REF_LO), .REF_HI(REF_HI),
             .PREV_INIT(PREV_INIT)) u_cref (
    .clk(clk), .rst_n(rst_n),
    .small_flat(wt_small), .shift_en(shift_en), .shift_delta(shift_delta)
  );
endmodule

// File: rtl/cal_tracker_chk.sv
module cal_tracker_chk #(
  parameter int N_SMALL = 16,
  parameter int N_LARGE = 32,
  parameter int WW      = 20,
  parameter int UW      = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  plan_valid,
  input logic                  plan_ready,
  input logic [1:0]            plan_flag,
  input logic [UW-1:0]         plan_unit,
  input logic                  plan_term,
  input logic                  upd_valid,
  input logic                  upd_ready,
  input logic [WW-1:0]         upd_delta,
  input logic [N_SMALL*WW-1:0] wt_small,
  input logic [N_LARGE*WW-1:0] wt_large
);
  logic [1:0]    lflag;
  logic [UW-1:0] lunit;
  logic [31:0]   lbase;
  logic          ufire;

  assign ufire = upd_valid && upd_ready;
  assign lbase = 32'(lunit) * 32'(WW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lflag <= 2'd0;
      lunit <= '0;
    end else if (plan_valid && plan_ready) begin
      lflag <= plan_flag;
      lunit <= plan_unit;
    end
  end

  // R8: plan held until taken
  a_r8_plan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    plan_valid && !plan_ready |=> plan_valid && $stable(plan_flag) &&
                                  $stable(plan_unit) && $stable(plan_term));
  // R8: the two channels never open together
  a_r8_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(plan_valid && upd_ready));
  // R2: small mode terminates on the large group
  a_r2_term_small: assert property (@(posedge clk) disable iff (!rst_n)
    plan_valid && plan_flag == 2'd1 |-> plan_term);
  // R3: large mode terminates on the small group
  a_r3_term_large: assert property (@(posedge clk) disable iff (!rst_n)
    plan_valid && plan_flag == 2'd2 |-> !plan_term);
  // R4: after the last large unit, the small pass restarts at unit 1
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    ufire && lflag == 2'd2 && lunit == UW'(N_LARGE - 1)
    |=> plan_valid && plan_flag == 2'd1 && plan_unit == UW'(1));
  // R5: small correction lands on the named unit
  a_r5_small_write: assert property (@(posedge clk) disable iff (!rst_n)
    ufire && lflag == 2'd1 |=> wt_small[lbase +: WW] == $past(wt_small[lbase +: WW] + upd_delta));
  // R7: silent cycle after the last small unit
  a_r7_shift_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ufire && lflag == 2'd1 && lunit == UW'(N_SMALL - 1) |=> !plan_valid && !upd_ready);
  // R9: small bank moves only on an accepted correction
  a_r9_small_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ufire |=> $stable(wt_small));
endmodule

bind cal_two_ref_tracker cal_tracker_chk #(
  .N_SMALL(N_SMALL), .N_LARGE(N_LARGE), .WW(WW), .UW(UW)
) u_chk (.*);

// File: tb/sim_cal_two_ref_tracker.sv
`timescale 1ns/1ps
module sim_cal_two_ref_tracker;
  localparam int NS = 16;
  localparam int NL = 32;
  localparam int WW = 20;
  localparam int UW = 5;
  localparam logic [WW-1:0] S_INIT = WW'(512);
  localparam logic [WW-1:0] L_INIT = WW'(4096);
  localparam int DELTA_TAB [8] = '{3, -5, 17, -1, 40, -22, 7, 0};
  localparam int HOLD_TAB  [8] = '{0, 2, 0, 1, 0, 0, 3, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic plan_valid, plan_ready, plan_term, upd_valid, upd_ready;
  logic [1:0] plan_flag;
  logic [UW-1:0] plan_unit;
  logic [WW-1:0] upd_delta;
  logic [NS*WW-1:0] wt_small;
  logic [NL*WW-1:0] wt_large;

  always #2 clk = ~clk;

  cal_two_ref_tracker u0 (
    .clk(clk), .rst_n(rst_n),
    .plan_valid(plan_valid), .plan_ready(plan_ready),
    .plan_flag(plan_flag), .plan_unit(plan_unit), .plan_term(plan_term),
    .upd_valid(upd_valid), .upd_ready(upd_ready), .upd_delta(upd_delta),
    .wt_small(wt_small), .wt_large(wt_large)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [WW-1:0] ms [NS];
  logic [WW-1:0] ml [NL];
  logic [WW-1:0] mprev;
  logic [1:0] ef;
  logic [UW-1:0] eu;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NS; i++) ms[i] = S_INIT;
    for (int i = 0; i < NL; i++) ml[i] = L_INIT;
    mprev = WW'(4096);
    ef = 2'd1;
    eu = UW'(1);
  endtask

  task automatic check_bank(input string req);
    bit good = 1'b1;
    logic [WW-1:0] a = '0, e = '0;
    for (int i = 0; i < NS; i++)
      if (good && wt_small[i*WW +: WW] !== ms[i]) begin good = 1'b0; a = wt_small[i*WW +: WW]; e = ms[i]; end
    for (int i = 0; i < NL; i++)
      if (good && wt_large[i*WW +: WW] !== ml[i]) begin good = 1'b0; a = wt_large[i*WW +: WW]; e = ml[i]; end
    chk(good, req, 32'(a), 32'(e));
  endtask

  task automatic wait_plan();
    int n = 0;
    while (!plan_valid && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic do_plan(input int hold, input logic [WW-1:0] d);
    string rq;
    logic [WW-1:0] s;
    wait_plan();
    rq = (ef == 2'd1) ? "R2" : "R3";
    chk(plan_valid && plan_flag == ef && plan_unit == eu && plan_term == (ef == 2'd1),
        rq, {25'd0, plan_flag, plan_unit}, {25'd0, ef, eu});
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(plan_valid && plan_flag == ef && plan_unit == eu && !upd_ready,
          "R8 hold", {25'd0, plan_flag, plan_unit}, {25'd0, ef, eu});
    end
    plan_ready = 1'b1;
    @(negedge clk);
    plan_ready = 1'b0;
    chk(!plan_valid && upd_ready, "R8 channel", {30'd0, plan_valid, upd_ready}, 32'd1);
    upd_valid = 1'b1;
    upd_delta = d;
    @(negedge clk);
    upd_valid = 1'b0;
    if (ef == 2'd1) ms[eu] = ms[eu] + d; else ml[eu] = ml[eu] + d;
    check_bank("R5 write");
    if (ef == 2'd1 && eu == UW'(NS - 1)) begin
      chk(!plan_valid && !upd_ready, "R7 gap", {30'd0, plan_valid, upd_ready}, 32'd0);
      @(negedge clk);
      s = '0;
      for (int i = 8; i <= 15; i++) s = s + ms[i];
      for (int i = 1; i < NL; i++) ml[i] = ml[i] + (s - mprev);
      mprev = s;
      check_bank("R7 shift");
      ef = 2'd2; eu = UW'(1);
    end else if (ef == 2'd1) begin
      eu = eu + UW'(1);
    end else if (eu == UW'(NL - 1)) begin
      chk(plan_valid && plan_flag == 2'd1 && plan_unit == UW'(1), "R4 restart",
          {25'd0, plan_flag, plan_unit}, {25'd0, 2'd1, 5'd1});
      ef = 2'd1; eu = UW'(1);
    end else begin
      eu = eu + UW'(1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    plan_ready = 1'b0;
    upd_valid = 1'b0;
    upd_delta = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_bank("R1 weights");
    chk(plan_valid && plan_flag == 2'd1 && plan_unit == UW'(1) && plan_term,
        "R1 plan", {24'd0, plan_term, plan_flag, plan_unit}, {24'd0, 1'b1, 2'd1, 5'd1});

    // vector walk: two full small+large rounds
    for (int s = 0; s < 2 * 46; s++)
      do_plan(HOLD_TAB[s % 8], WW'(DELTA_TAB[s % 8]));

    // R6 reference entries untouched
    chk(wt_small[0 +: WW] == S_INIT, "R6 small0", 32'(wt_small[0 +: WW]), 32'(S_INIT));
    chk(wt_large[0 +: WW] == L_INIT, "R6 large0", 32'(wt_large[0 +: WW]), 32'(L_INIT));

    // R9 correction while upd_ready low is ignored
    wait_plan();
    upd_valid = 1'b1;
    upd_delta = WW'(100);
    repeat (3) @(negedge clk);
    upd_valid = 1'b0;
    check_bank("R9 ignored");
    chk(plan_valid && plan_unit == eu, "R9 plan kept", 32'(plan_unit), 32'(eu));

    // R10 wrap below zero
    do_plan(0, WW'(-2000));
    chk(wt_small[1*WW +: WW] == ms[1] && ms[1][WW-1], "R10 wrap",
        32'(wt_small[1*WW +: WW]), 32'(ms[1]));

    // R1 mid-run reset, then a full small pass to confirm the composite baseline
    rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    check_bank("R1 async reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(plan_valid && plan_flag == 2'd1 && plan_unit == UW'(1), "R1 replan",
        {25'd0, plan_flag, plan_unit}, {25'd0, 2'd1, 5'd1});
    for (int s = 0; s < NS - 1; s++)
      do_plan(0, WW'(DELTA_TAB[(s + 3) % 8] * 5));

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule